// File: doc/BRIEF.md
# Tower-Field Byte Inverter

This block returns the multiplicative inverse of one byte in GF(2^8). The byte is read in the standard polynomial basis of the field reduced by x^8+x^4+x^3+x^2+1. The block does not invert in the 8-bit field directly. It first maps the byte into a two-level tower field, GF((2^4)^2), with a constant 8x8 binary matrix. It then inverts there using only 4-bit multiply, square and invert operations, and maps the result back with the inverse matrix. Both matrices are XOR trees. The package works them out at elaboration: it searches for a tower element that is a root of the byte field's polynomial, and it inverts the resulting matrix by Gauss-Jordan elimination. No matrix is written out by hand.

The tower uses the 4-bit field reduced by x^4+x+1. The extension polynomial is x^2 + x + 8, where 8 is the 4-bit element with only bit 3 set. A tower element holds the x-coefficient in bits 7:4 and the constant coefficient in bits 3:0. The term (a0 + a1·p1) is formed once. It feeds both the denominator and the low output coefficient.

Each input accepted with the valid flag produces one registered result, one clock later. The block is the nonlinear core of a byte substitution box. The affine step that usually follows it is not part of this block.

Top module: `gf256_tower_inv`

## Requirements
- R1: For every nonzero input byte a accepted with in_valid, out_byte is the byte b for which a·b = 0x01 in GF(2^8) with reduction polynomial 0x11D (bit i is the coefficient of x^i).
- R2: An accepted input of 0x00 yields out_byte = 0x00.
- R3: out_valid is high in the cycle after a cycle in which in_valid was high, and low after a cycle in which in_valid was low. Results come out in the order the inputs were accepted.
- R4: While in_valid is low, out_byte keeps its last value, whatever in_byte carries.
- R5: While rst_n is low, out_valid and out_byte are both 0.
- R6: Feeding a result back in returns the original byte: inv(inv(a)) = a for all nonzero a.
- R7: Inputs may be accepted on every consecutive cycle, with one result per cycle and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte is to be inverted this cycle |
| in_byte | input | 8 | Operand, standard basis |
| out_valid | output | 1 | out_byte carries a fresh result |
| out_byte | output | 8 | Inverse, standard basis |

## Verification
On every clock the assertions check four things: the product of the previous operand and the current result is one; zero maps to zero; the valid flag follows its input one cycle late; and the output holds while no input is accepted. Inside the datapath, further assertions check that the 4-bit denominator is never zero for a nonzero operand and that the 4-bit inverse really inverts. Only the bench's scenarios can show some properties. These are the exact value against an independently computed inverse for all 256 operands, in order, through back-to-back streams and gapped streams; the round trip through a second inversion; and the reset values.

// File: rtl/gft_pkg.sv
package gft_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    localparam logic [BYTE_W:0]  BASE_POLY = 9'h11D;
    localparam logic [NIB_W-1:0] SUB_RED   = 4'h3;
    localparam logic [NIB_W-1:0] TOWER_P1  = 4'h1;
    localparam logic [NIB_W-1:0] TOWER_P0  = 4'h8;

    typedef logic [BYTE_W-1:0][BYTE_W-1:0] bmat_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] res;
    } out_st_t;

    function automatic logic [NIB_W-1:0] nib_mul(logic [NIB_W-1:0] a, logic [NIB_W-1:0] b);
        logic [NIB_W-1:0] acc;
        logic [NIB_W-1:0] sh;
        logic             cy;
        acc = '0;
        sh  = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            cy = sh[NIB_W-1];
            sh = {sh[NIB_W-2:0], 1'b0};
            if (cy) sh = sh ^ SUB_RED;
        end
        return acc;
    endfunction

    function automatic logic [BYTE_W-1:0] byte_mul(logic [BYTE_W-1:0] a, logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        logic              cy;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            cy = sh[BYTE_W-1];
            sh = {sh[BYTE_W-2:0], 1'b0};
            if (cy) sh = sh ^ BASE_POLY[BYTE_W-1:0];
        end
        return acc;
    endfunction

    function automatic logic [BYTE_W-1:0] tower_mul(logic [BYTE_W-1:0] x, logic [BYTE_W-1:0] y);
        logic [NIB_W-1:0] hh;
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        hh = nib_mul(x[BYTE_W-1:NIB_W], y[BYTE_W-1:NIB_W]);
        hi = nib_mul(x[BYTE_W-1:NIB_W], y[NIB_W-1:0]) ^ nib_mul(x[NIB_W-1:0], y[BYTE_W-1:NIB_W])
           ^ nib_mul(hh, TOWER_P1);
        lo = nib_mul(x[NIB_W-1:0], y[NIB_W-1:0]) ^ nib_mul(hh, TOWER_P0);
        return {hi, lo};
    endfunction

    function automatic logic [BYTE_W-1:0] find_root();
        logic [BYTE_W-1:0] hit;
        logic [BYTE_W-1:0] sum;
        logic [BYTE_W-1:0] pw;
        hit = '0;
        for (int c = 2; c < (1 << BYTE_W); c++) begin
            if (hit == '0) begin
                sum = '0;
                pw  = 8'h01;
                for (int k = 0; k <= BYTE_W; k++) begin
                    if (BASE_POLY[k]) sum = sum ^ pw;
                    pw = tower_mul(pw, c[BYTE_W-1:0]);
                end
                if (sum == '0) hit = c[BYTE_W-1:0];
            end
        end
        return hit;
    endfunction

    function automatic bmat_t build_fwd_rows();
        bmat_t             rows;
        logic [BYTE_W-1:0] beta;
        logic [BYTE_W-1:0] pw;
        rows = '0;
        beta = find_root();
        pw   = 8'h01;
        for (int i = 0; i < BYTE_W; i++) begin
            for (int r = 0; r < BYTE_W; r++) rows[r][i] = pw[r];
            pw = tower_mul(pw, beta);
        end
        return rows;
    endfunction

    function automatic bmat_t invert_rows(bmat_t rows);
        logic [BYTE_W-1:0][2*BYTE_W-1:0] aug;
        logic [2*BYTE_W-1:0]             tmp;
        bmat_t                           res;
        int                              piv;
        logic                            got;
        for (int r = 0; r < BYTE_W; r++) begin
            aug[r]    = {rows[r], {BYTE_W{1'b0}}};
            aug[r][r] = 1'b1;
        end
        for (int c = 0; c < BYTE_W; c++) begin
            piv = c;
            got = 1'b0;
            for (int p = c; p < BYTE_W; p++) begin
                if (!got && aug[p][BYTE_W+c]) begin
                    piv = p;
                    got = 1'b1;
                end
            end
            tmp      = aug[c];
            aug[c]   = aug[piv];
            aug[piv] = tmp;
            for (int r = 0; r < BYTE_W; r++) begin
                if (r != c && aug[r][BYTE_W+c]) aug[r] = aug[r] ^ aug[c];
            end
        end
        for (int r = 0; r < BYTE_W; r++) res[r] = aug[r][BYTE_W-1:0];
        return res;
    endfunction

    localparam bmat_t TO_TOWER   = build_fwd_rows();
    localparam bmat_t FROM_TOWER = invert_rows(TO_TOWER);

endpackage

// File: rtl/gf_basis_map.sv
module gf_basis_map #(
    parameter int                          W    = 8,
    parameter logic [W-1:0][W-1:0]         ROWS = '0
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    for (genvar r = 0; r < W; r++) begin : g_row
        assign dst[r] = ^(src & ROWS[r]);
    end
endmodule

// File: rtl/gf16_mul.sv
module gf16_mul
    import gft_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    output logic [NIB_W-1:0] p
);
    assign p = nib_mul(a, b);
endmodule

// File: rtl/gf16_inv.sv
module gf16_inv
    import gft_pkg::*;
(
    input  logic [NIB_W-1:0] a,
    output logic [NIB_W-1:0] y
);
    logic [NIB_W-1:0] a2_d, a4_d, a8_d, a6_d;

    always_comb begin
        a2_d = nib_mul(a, a);
        a4_d = nib_mul(a2_d, a2_d);
        a8_d = nib_mul(a4_d, a4_d);
    end

    gf16_mul u_m6  (.a(a2_d), .b(a4_d), .p(a6_d));
    gf16_mul u_m14 (.a(a6_d), .b(a8_d), .p(y));

    always_comb begin
        if (a != '0) begin
            a_r1_nib_inverse: assert (nib_mul(a, y) == 4'h1)
                else $error("R1 nibble inverse wrong");
        end
    end
endmodule

// File: rtl/tower_inv.sv
module tower_inv
    import gft_pkg::*;
(
    input  logic [BYTE_W-1:0] t_in,
    output logic [BYTE_W-1:0] t_out
);
    logic [NIB_W-1:0] hi_d, lo_d;
    logic [NIB_W-1:0] hp1_d, share_d, lo_sh_d, hsq_d, hsq_p0_d;
    logic [NIB_W-1:0] delta_d, dinv_d, b1_d, b0_d;

    assign hi_d = t_in[BYTE_W-1:NIB_W];
    assign lo_d = t_in[NIB_W-1:0];

    gf16_mul u_hp1 (.a(hi_d), .b(TOWER_P1), .p(hp1_d));

    always_comb begin
        share_d = lo_d ^ hp1_d;
        hsq_d   = nib_mul(hi_d, hi_d);
    end

    gf16_mul u_lsh (.a(lo_d),  .b(share_d),  .p(lo_sh_d));
    gf16_mul u_hp0 (.a(hsq_d), .b(TOWER_P0), .p(hsq_p0_d));

    assign delta_d = lo_sh_d ^ hsq_p0_d;

    gf16_inv u_dinv (.a(delta_d), .y(dinv_d));

    gf16_mul u_b1 (.a(hi_d),    .b(dinv_d), .p(b1_d));
    gf16_mul u_b0 (.a(share_d), .b(dinv_d), .p(b0_d));

    assign t_out = {b1_d, b0_d};

    always_comb begin
        if (t_in != '0) begin
            a_r1_delta_nonzero: assert (delta_d != '0)
                else $error("R1 zero denominator for nonzero operand");
        end
    end
endmodule

// File: rtl/gf256_tower_inv.sv
module gf256_tower_inv
    import gft_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic [BYTE_W-1:0] tw_in, tw_inv, inv_byte;

    gf_basis_map #(.W(BYTE_W), .ROWS(TO_TOWER))   u_fwd (.src(in_byte), .dst(tw_in));
    tower_inv                                     u_inv (.t_in(tw_in), .t_out(tw_inv));
    gf_basis_map #(.W(BYTE_W), .ROWS(FROM_TOWER)) u_bwd (.src(tw_inv), .dst(inv_byte));

    if (REGISTER_OUT) begin : g_reg
        out_st_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = in_valid;
            if (in_valid) st_d.res = inv_byte;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign out_valid = st_q.vld;
        assign out_byte  = st_q.res;

        a_r1_product_one: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte != '0) |=> (byte_mul($past(in_byte), out_byte) == 8'h01))
            else $error("R1 product not one");

        a_r2_zero_maps_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte == '0) |=> (out_byte == '0))
            else $error("R2 zero not preserved");

        a_r3_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid)
            else $error("R3 missing out_valid");

        a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid)
            else $error("R3 spurious out_valid");

        a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_byte))
            else $error("R4 output moved while idle");
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_byte  = inv_byte;
    end
endmodule

// File: tb/sim_gf256_tower_inv.sv
`timescale 1ns/1ps
module sim_gf256_tower_inv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] opd_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gf256_tower_inv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h11D << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] ref_inv(logic [7:0] a);
        logic [7:0] r = 8'h00;
        for (int c = 1; c < 256; c++) if (ref_mul(a, c[7:0]) == 8'h01) r = c[7:0];
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [7:0] v, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = v;
        exp_q.push_back(ref_inv(v));
        opd_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor: pops the scoreboard whenever a result is flagged
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R3", 8'h01, 8'h00, "result without pending input");
            end else begin
                logic [7:0] e, o;
                string      t;
                e = exp_q.pop_front();
                o = opd_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_byte, e, $sformatf("inverse of %02h", o));
            end
        end
    end

    task automatic idle_hold(int n, logic [7:0] last);
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_byte = in_byte + 8'h3B;
            check("R4", out_byte, last, "held output while idle");
            check("R3", {7'd0, out_valid}, 8'h00, "out_valid low while idle");
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset values
        check("R5", {7'd0, out_valid}, 8'h00, "out_valid in reset");
        check("R5", out_byte, 8'h00, "out_byte in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: zero in, zero out
        send(8'h00, "R2");
        // R1: single values with a gap between them (R3 ordering)
        send(8'h01, "R1");
        idle_hold(2, 8'h01);
        send(8'h02, "R1");
        idle_hold(1, ref_inv(8'h02));
        send(8'h53, "R1");
        send(8'hFF, "R1");
        idle_hold(3, ref_inv(8'hFF));

        // R7: full back-to-back sweep of all nonzero bytes
        for (int i = 1; i < 256; i++) send(i[7:0], "R7");
        idle_hold(3, ref_inv(8'hFF));

        // R6: feed inverses back in; result must be the original byte
        for (int i = 1; i < 256; i++) begin
            logic [7:0] v;
            v = ref_inv(i[7:0]);
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = v;
            exp_q.push_back(i[7:0]);
            opd_q.push_back(v);
            tag_q.push_back("R6");
        end
        idle_hold(2, 8'hFF);

        // R3: gapped stream alternating valid and idle
        for (int i = 0; i < 16; i++) begin
            send(8'(i * 17 + 3), "R3");
            @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R3", 8'(exp_q.size()), 8'h00, "pending results at end");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule